// File: doc/BRIEF.md
# NCO CORDIC Downconversion Mixer

This block mixes a real stream of 16-bit two's-complement samples down to complex baseband. A 32-bit phase accumulator adds a programmable frequency word on every clock. The top 16 bits of that phase drive a pipelined CORDIC rotator. The rotator turns the vector (x, 0) through the phase angle, so the in-phase output approximates x·cos(θ) and the quadrature output approximates x·sin(θ). A constant pre-scale cancels the CORDIC gain, which keeps the output amplitude equal to the input amplitude. The result is rounded and clamped to 16 bits.

To bring a carrier at frequency f down to zero, write the frequency word as the two's-complement negative of f/fs·2^32. For example, 0xB0000000 steps the phase by −112.5° per sample, which moves a 20 MHz tone sampled at 64 MHz to DC.

A mode bit selects bypass. In bypass, a separate I/Q pair that is already at baseband passes through unchanged, with the same latency as the rotation path. The mode travels with each sample, so a mode change never tears the stream. Both registers are written over a simple serial-style bus made of a strobe, an address and a data word.

Top module: `nco_cordic_mixer`

## Requirements
- R1: A synchronous reset clears the phase, the frequency word, the mode bit and every pipeline register. Both outputs read 0 in the cycle after reset and until new data drains through.
- R2: A cycle with `cfg_stb` high and `cfg_addr` = 0 loads `cfg_data` into the frequency word. A strobe at any address other than 0 or 1 changes neither register.
- R3: On every clock, the phase becomes phase + frequency word, modulo 2^32. Loading a new frequency word does not reset the phase.
- R4: In rotate mode, `i_out` is within 24 LSB of x·cos(2π·P/65536) and `q_out` is within 24 LSB of x·sin(2π·P/65536). Here P is the top 16 bits of the phase held in the cycle the sample x was accepted.
- R5: The rotation covers all four quadrants. P[15:14] selects a quarter-turn pre-rotation, and the lower 14 bits are resolved by the CORDIC stages.
- R6: Results beyond 16 bits clamp to 32767 or −32768.
- R7: The latency is STAGES+1 clock cycles (17 by default) in both modes.
- R8: A strobe at `cfg_addr` = 1 loads `cfg_data[0]` into the mode bit, where 1 selects bypass. In bypass, `i_out`/`q_out` equal `i_in`/`q_in` exactly and `x_in` is ignored.
- R9: The mode bit is captured with each sample. A mode change takes effect for the samples accepted after the write, and earlier samples leave in their own mode.
- R10: A negative frequency word rotates the phase backwards. For example, 0xB0000000 steps P by −0x5000 per sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_stb | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration register address |
| cfg_data | input | 32 | Configuration write data |
| x_in | input | 16 | Real input sample, two's complement |
| i_in | input | 16 | Baseband in-phase input for bypass |
| q_in | input | 16 | Baseband quadrature input for bypass |
| i_out | output | 16 | In-phase result |
| q_out | output | 16 | Quadrature result |

## Verification
The bench first holds the phase still, with a zero frequency word, and sweeps the input across its whole range. This isolates gain and rounding from the angle path. A coarse step then sends a constant amplitude around the full circle, and a fine step combined with a varying input covers nearly every phase and amplitude pair. These runs separate quadrant mistakes from errors in the CORDIC stages. Full-scale negative and positive inputs push the result past 16 bits to exercise the clamp. The negative word 0xB0000000 exposes a sign error in the accumulator. Mid-stream frequency writes, writes to unused addresses, per-cycle mode toggling and single-sample markers in both modes then show phase continuity, decode selectivity, per-sample mode alignment and the exact latency.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;
  localparam int SMP_W     = 16;
  localparam int GUARD_W   = 2;
  localparam int CORE_W    = SMP_W + GUARD_W + 2;
  localparam int ANG_W     = 16;
  localparam int RES_W     = ANG_W + 2;
  localparam int GAIN_FRAC = 15;
  localparam logic signed [31:0] INV_GAIN = 32'sd19898;  // round(2^15 / 1.64676)

  typedef logic signed [SMP_W-1:0]  smp_t;
  typedef logic signed [CORE_W-1:0] core_t;
  typedef logic signed [RES_W-1:0]  res_t;

  localparam core_t SAT_HI = core_t'(2**(SMP_W-1) - 1);
  localparam core_t SAT_LO = core_t'(-(2**(SMP_W-1)));

  // atan(2^-k) in units of 2*pi/2^ANG_W
  function automatic res_t step_angle(input int k);
    case (k)
      0: return res_t'(8192);   1: return res_t'(4836);
      2: return res_t'(2555);   3: return res_t'(1297);
      4: return res_t'(651);    5: return res_t'(326);
      6: return res_t'(163);    7: return res_t'(81);
      8: return res_t'(41);     9: return res_t'(20);
      10: return res_t'(10);    11: return res_t'(5);
      12: return res_t'(3);     13: return res_t'(1);
      14: return res_t'(1);
      default: return res_t'(0);
    endcase
  endfunction

  // input times 1/K, left with GUARD_W fraction bits
  function automatic core_t prescale(input smp_t s);
    logic signed [31:0] wide;
    wide = {{(32-SMP_W){s[SMP_W-1]}}, s};
    wide = wide * INV_GAIN;
    return core_t'(wide >>> (GAIN_FRAC - GUARD_W));
  endfunction

  // drop guard bits with rounding, then clamp to the sample range
  function automatic smp_t round_sat(input core_t v);
    core_t r;
    r = (v + core_t'(1 << (GUARD_W-1))) >>> GUARD_W;
    if (r > SAT_HI) return smp_t'(SAT_HI);
    if (r < SAT_LO) return smp_t'(SAT_LO);
    return smp_t'(r);
  endfunction
endpackage

// File: rtl/nco_regs.sv
module nco_regs
  import nco_mix_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int ACC_W  = 32,
  parameter logic [ADDR_W-1:0] FREQ_ADDR = '0,
  parameter logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_stb,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ACC_W-1:0]  cfg_data,
  output logic [ANG_W-1:0]  ang_o,
  output logic              bypass_q
);
  logic [ACC_W-1:0] phase_q;
  logic [ACC_W-1:0] freq_q;
  logic freq_hit;
  logic mode_hit;

  assign freq_hit = cfg_stb && (cfg_addr == FREQ_ADDR);
  assign mode_hit = cfg_stb && (cfg_addr == MODE_ADDR);
  assign ang_o    = phase_q[ACC_W-1 -: ANG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= '0;
      freq_q   <= '0;
      bypass_q <= 1'b0;
    end else begin
      phase_q <= phase_q + freq_q;
      if (freq_hit) freq_q   <= cfg_data;
      if (mode_hit) bypass_q <= cfg_data[0];
    end
  end

  AST_FREQ_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst) !freq_hit |=> $stable(freq_q)); // R2
  AST_MODE_ON_WRITE: assert property (@(posedge clk) disable iff (rst) mode_hit |=> (bypass_q == $past(cfg_data[0]))); // R8
  AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (rst) (freq_q == '0) |=> $stable(phase_q)); // R3
endmodule

// File: rtl/cordic_pipe.sv
module cordic_pipe
  import nco_mix_pkg::*;
#(
  parameter int STAGES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  smp_t             x_in,
  input  logic [ANG_W-1:0] ang_in,
  output core_t            x_out,
  output core_t            y_out
);
  localparam res_t RES_BOUND = step_angle(STAGES-1) + res_t'(STAGES);

  core_t xs [0:STAGES];
  core_t ys [0:STAGES];
  res_t  zs [0:STAGES];
  core_t scaled;

  assign scaled = prescale(x_in);
  assign x_out  = xs[STAGES];
  assign y_out  = ys[STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s <= STAGES; s++) begin
        xs[s] <= '0;
        ys[s] <= '0;
        zs[s] <= '0;
      end
    end else begin
      // quarter-turn pre-rotation from the two top phase bits
      case (ang_in[ANG_W-1 -: 2])
        2'b00: begin xs[0] <= scaled;  ys[0] <= '0;      end
        2'b01: begin xs[0] <= '0;      ys[0] <= scaled;  end
        2'b10: begin xs[0] <= -scaled; ys[0] <= '0;      end
        default: begin xs[0] <= '0;    ys[0] <= -scaled; end
      endcase
      zs[0] <= res_t'(ang_in[ANG_W-3:0]);
      for (int s = 0; s < STAGES; s++) begin
        if (!zs[s][RES_W-1]) begin
          xs[s+1] <= xs[s] - (ys[s] >>> s);
          ys[s+1] <= ys[s] + (xs[s] >>> s);
          zs[s+1] <= zs[s] - step_angle(s);
        end else begin
          xs[s+1] <= xs[s] + (ys[s] >>> s);
          ys[s+1] <= ys[s] - (xs[s] >>> s);
          zs[s+1] <= zs[s] + step_angle(s);
        end
      end
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_chk
    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst) (xs[g] == '0 && ys[g] == '0) |=> (xs[g+1] == '0 && ys[g+1] == '0)); // R4
  end
  AST_ANGLE_CONVERGED: assert property (@(posedge clk) disable iff (rst) (zs[STAGES] <= RES_BOUND) && (zs[STAGES] >= -RES_BOUND)); // R5
endmodule

// File: rtl/tap_delay.sv
module tap_delay #(
  parameter int W     = 33,
  parameter int DEPTH = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] taps [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) taps[k] <= '0;
    end else begin
      taps[0] <= d;
      for (int k = 1; k < DEPTH; k++) taps[k] <= taps[k-1];
    end
  end

  assign q = taps[DEPTH-1];
endmodule

// File: rtl/nco_cordic_mixer.sv
module nco_cordic_mixer
  import nco_mix_pkg::*;
#(
  parameter int STAGES = 16,
  parameter int ADDR_W = 7,
  parameter int ACC_W  = 32,
  parameter logic [ADDR_W-1:0] FREQ_ADDR = '0,
  parameter logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_stb,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [ACC_W-1:0]        cfg_data,
  input  logic signed [SMP_W-1:0] x_in,
  input  logic signed [SMP_W-1:0] i_in,
  input  logic signed [SMP_W-1:0] q_in,
  output logic signed [SMP_W-1:0] i_out,
  output logic signed [SMP_W-1:0] q_out
);
  localparam int LAT    = STAGES + 1;
  localparam int PASS_W = 1 + 2*SMP_W;

  logic [ANG_W-1:0]  ang;
  logic              bypass_q;
  core_t             rot_x, rot_y;
  smp_t              rot_i, rot_q;
  logic [PASS_W-1:0] pass_d, pass_q;
  logic              pass_bp;
  smp_t              pass_i, pass_q_s;

  nco_regs #(
    .ADDR_W(ADDR_W), .ACC_W(ACC_W), .FREQ_ADDR(FREQ_ADDR), .MODE_ADDR(MODE_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_stb(cfg_stb), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .ang_o(ang), .bypass_q(bypass_q)
  );

  cordic_pipe #(.STAGES(STAGES)) u_rot (
    .clk(clk), .rst(rst), .x_in(x_in), .ang_in(ang),
    .x_out(rot_x), .y_out(rot_y)
  );

  // bypass data and the per-sample mode bit ride a matching delay line
  assign pass_d = {bypass_q, i_in, q_in};

  tap_delay #(.W(PASS_W), .DEPTH(LAT)) u_pass (
    .clk(clk), .rst(rst), .d(pass_d), .q(pass_q)
  );

  assign pass_bp  = pass_q[PASS_W-1];
  assign pass_i   = pass_q[2*SMP_W-1 -: SMP_W];
  assign pass_q_s = pass_q[SMP_W-1:0];
  assign rot_i    = round_sat(rot_x);
  assign rot_q    = round_sat(rot_y);
  assign i_out    = pass_bp ? pass_i   : rot_i;
  assign q_out    = pass_bp ? pass_q_s : rot_q;

  AST_RESET_OUT: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (i_out == '0 && q_out == '0)); // R1
endmodule

// File: tb/nco_cordic_mixer_tb.sv
module nco_cordic_mixer_tb;
  localparam int LAT = 17;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        cfg_stb = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic signed [15:0] x_in = '0, i_in = '0, q_in = '0;
  wire  signed [15:0] i_out, q_out;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit chk_on = 1'b0;

  nco_cordic_mixer u_dut (
    .clk(clk), .rst(rst), .cfg_stb(cfg_stb), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .x_in(x_in), .i_in(i_in), .q_in(q_in), .i_out(i_out), .q_out(q_out)
  );

  // bench-side model of the registers and per-sample history
  logic [31:0] m_acc, m_freq;
  logic        m_bp;
  int          m_cnt;
  logic [15:0] h_ang [0:31];
  logic signed [15:0] h_x [0:31];
  logic signed [15:0] h_i [0:31];
  logic signed [15:0] h_q [0:31];
  logic        h_bp [0:31];

  always @(posedge clk) begin
    if (rst) begin
      m_acc <= '0; m_freq <= '0; m_bp <= 1'b0; m_cnt <= 0;
    end else begin
      h_ang[m_cnt % 32] <= m_acc[31:16];
      h_x[m_cnt % 32]   <= x_in;
      h_i[m_cnt % 32]   <= i_in;
      h_q[m_cnt % 32]   <= q_in;
      h_bp[m_cnt % 32]  <= m_bp;
      m_acc <= m_acc + m_freq;
      if (cfg_stb && cfg_addr == 7'd0) m_freq <= cfg_data;
      if (cfg_stb && cfg_addr == 7'd1) m_bp <= cfg_data[0];
      m_cnt <= m_cnt + 1;
    end
  end

  task automatic check_val(input string req, input string what, input int act, input int exp, input int tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clampi(input real r);
    if (r > 32767.0) return 32767;
    if (r < -32768.0) return -32768;
    return int'(r);
  endfunction

  // continuous comparison of every output sample against its input LAT cycles earlier
  int  k;
  real th, ei, eq;
  always @(negedge clk) begin
    if (chk_on && !rst && m_cnt >= LAT) begin
      k = (m_cnt - LAT) % 32;
      if (h_bp[k]) begin
        check_val(cur_req, "bypass I", int'(i_out), int'(h_i[k]), 0);
        check_val(cur_req, "bypass Q", int'(q_out), int'(h_q[k]), 0);
      end else begin
        th = TWO_PI * real'(h_ang[k]) / 65536.0;
        ei = real'(h_x[k]) * $cos(th);
        eq = real'(h_x[k]) * $sin(th);
        check_val(cur_req, "rotated I", int'(i_out), clampi(ei), 24);
        check_val(cur_req, "rotated Q", int'(q_out), clampi(eq), 24);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic cfg_write(input logic [6:0] a, input logic [31:0] d);
    cfg_stb = 1'b1; cfg_addr = a; cfg_data = d;
    @(posedge clk); #1;
    cfg_stb = 1'b0;
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int seen;
    // R1: reset state
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_val("R1", "I in reset", int'(i_out), 0, 0);
    check_val("R1", "Q in reset", int'(q_out), 0, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    chk_on = 1'b1;

    // R4: phase held at zero, sweep input amplitude
    cur_req = "R4";
    for (int n = 0; n < 600; n++) begin x_in = 16'(n * 109 - 32768); run(1); end

    // R5: coarse full circle at constant amplitude, then fine phase with varying input
    cur_req = "R5";
    cfg_write(7'd0, 32'h0100_0000);
    x_in = 16'sd20000;
    run(300);
    cfg_write(7'd0, 32'h0008_0000);
    for (int n = 0; n < 8200; n++) begin x_in = 16'(n * 2749); run(1); end

    // R6: full-scale inputs around the circle drive the clamp
    cur_req = "R6";
    cfg_write(7'd0, 32'h0100_0000);
    x_in = -16'sd32768;
    run(300);
    x_in = 16'sd32767;
    run(100);

    // R10: negative frequency word
    cur_req = "R10";
    cfg_write(7'd0, 32'hB000_0000);
    x_in = 16'sd12000;
    run(100);

    // R3: new frequency words mid-stream keep the phase running
    cur_req = "R3";
    x_in = 16'sd15000;
    cfg_write(7'd0, 32'h0123_4567);
    run(50);
    cfg_write(7'd0, 32'h0300_0000);
    run(50);

    // R2: strobes at unused addresses leave both registers alone
    cur_req = "R2";
    cfg_write(7'd9, 32'h4000_0001);
    cfg_write(7'd127, 32'hFFFF_FFFF);
    run(60);

    // R8: bypass passes I/Q exactly and ignores x_in
    cur_req = "R8";
    cfg_write(7'd1, 32'h0000_0001);
    for (int n = 0; n < 300; n++) begin
      i_in = 16'(n * 257 - 32768); q_in = 16'(32767 - n * 311); x_in = 16'(n * 7919);
      run(1);
    end

    // R9: mode toggles while samples stream
    cur_req = "R9";
    for (int n = 0; n < 240; n++) begin
      cfg_stb = (n % 3 == 0); cfg_addr = 7'd1; cfg_data = {31'b0, n[2]};
      x_in = 16'(n * 4001); i_in = 16'(n * 97); q_in = 16'(-n * 131);
      run(1);
    end
    cfg_stb = 1'b0;

    // R7: bypass marker appears after exactly LAT edges
    cur_req = "R7";
    cfg_write(7'd1, 32'h0000_0001);
    i_in = '0; q_in = '0;
    run(20);
    i_in = 16'sd1234;
    seen = 0;
    for (int c = 1; c <= LAT + 3; c++) begin
      @(posedge clk); #1;
      if (c == 1) i_in = '0;
      if (i_out == 16'sd1234 && seen == 0) seen = c;
    end
    check_val("R7", "bypass latency", seen, LAT, 0);

    // R1: reset mid-run clears phase, frequency and mode
    chk_on = 1'b0;
    rst = 1'b1;
    x_in = '0;
    run(3);
    @(negedge clk);
    check_val("R1", "I after reset", int'(i_out), 0, 0);
    check_val("R1", "Q after reset", int'(q_out), 0, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    chk_on = 1'b1;
    cur_req = "R1";
    run(25);

    // R7: rotation marker with phase cleared to zero
    cur_req = "R7";
    x_in = 16'sd16000;
    seen = 0;
    for (int c = 1; c <= LAT + 3; c++) begin
      @(posedge clk); #1;
      if (c == 1) x_in = '0;
      if (i_out > 16'sd15970 && i_out < 16'sd16030 && seen == 0) seen = c;
    end
    check_val("R7", "rotate latency", seen, LAT, 0);
    run(20);

    chk_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule